// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block watches the instruction sitting in decode and the instruction sitting in execute of an in-order pipeline. When the execute-stage instruction is a load that will write a register, and that register is one of the two operands the decode-stage instruction reads, the value cannot be forwarded in time: it only exists after the memory access. The unit then freezes the program counter and the fetch/decode latch for one cycle and sends a bubble into the decode/execute latch. The load itself keeps moving, and on the following cycle the waiting instruction can take the loaded value from the memory stage.

The block carries a small model of the front of the pipeline: a program counter that counts instruction slots, a fetch/decode latch, a decode/execute latch and an execute/memory latch. Each instruction carries a tag so that its position in the pipeline can be seen at the ports. Fetched instruction fields come in from outside, selected by the current `pc`. Branch flushing is not part of this block.

Top module: `loadUseStall`

## Requirements
- R1: `bubble` is high in a cycle exactly when the execute stage holds an instruction with `exRegWr`=1, `exLoad`=1 and a nonzero `exDst` equal to either decode-stage source register.
- R2: While `bubble` is high, `pcEn` and `fdEn` are low, and on the next cycle `pc` and `decTag` are unchanged. While it is low, both enables are high.
- R3: The slot loaded into the decode/execute latch during a stall has register write, memory write and load flag all 0, and tag 0.
- R4: In the stall cycle, the load moves from execute to memory: `memTag` and `memRegWr` on the next cycle equal `exTag` and `exRegWr` of the stall cycle.
- R5: A load followed by a dependent instruction gives exactly one bubble. An instruction two slots after the load is not stalled.
- R6: A load with destination register 0 never causes a stall.
- R7: There is no stall when the execute instruction is not a load, is a load without register write, or is a load whose destination matches neither source register. Independent instructions flow one per cycle.
- R8: Back-to-back loads, each dependent on the one before, stall at most once per dependent instruction. The stall depends only on the current latch contents.
- R9: After reset, `pc` is 0, all latches hold an empty slot (tag 0, all control bits 0), `bubble` is 0 and both enables are 1.
- R10: `pc` advances by exactly one on every clock edge on which `pcEn` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchTag | input | TAG_W | Tag of the instruction at `pc` |
| fetchDst | input | REG_W | Destination register of fetched instruction |
| fetchSrc1 | input | REG_W | First source register of fetched instruction |
| fetchSrc2 | input | REG_W | Second source register of fetched instruction |
| fetchRegWr | input | 1 | Fetched instruction writes a register |
| fetchMemWr | input | 1 | Fetched instruction writes memory |
| fetchLoad | input | 1 | Fetched instruction is a load |
| pc | output | PC_W | Instruction slot counter |
| pcEn | output | 1 | Program counter advance enable |
| fdEn | output | 1 | Fetch/decode latch load enable |
| bubble | output | 1 | Empty slot inserted into decode/execute latch |
| decTag | output | TAG_W | Tag in the fetch/decode latch |
| exTag | output | TAG_W | Tag in the decode/execute latch |
| exDst | output | REG_W | Destination register in execute |
| exRegWr | output | 1 | Register write bit in execute |
| exMemWr | output | 1 | Memory write bit in execute |
| exLoad | output | 1 | Load flag in execute |
| memTag | output | TAG_W | Tag in the execute/memory latch |
| memRegWr | output | 1 | Register write bit in memory stage |

## Verification
Every cycle, the assertions check that the enables are the inverse of the bubble, that a stall holds `pc` and the decode tag, that the inserted slot carries no writes, that the load advances to memory during the stall, that destination 0 never stalls, and that a bubble is never followed by another. The bench's program scenarios are needed to show that the stall fires for a dependency on each source, that it stays off for independent, second-following, non-load and write-less-load consumers, and that a chain of dependent loads costs one bubble per link.

// File: rtl/lus_pkg.sv
package lus_pkg;
  // Strobes passed from the hazard control to the pipeline datapath.
  typedef struct packed {
    logic pcEn;    // program counter may advance
    logic fdEn;    // fetch/decode latch may load
    logic bubble;  // decode/execute latch takes an empty slot
  } lus_strobe_t;

  localparam int SRC_CNT = 2;
endpackage

// File: rtl/hazardCtrl.sv
module hazardCtrl
  import lus_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [SRC_CNT-1:0][REG_W-1:0] decSrc,
  input  logic [REG_W-1:0]              exDst,
  input  logic                          exRegWr,
  input  logic                          exLoad,
  output lus_strobe_t                   strobes
);
  logic [SRC_CNT-1:0] srcMatch;
  logic               loadWriter;
  logic               useHit;

  genvar gi;
  generate
    for (gi = 0; gi < SRC_CNT; gi++) begin : g_cmp
      assign srcMatch[gi] = (decSrc[gi] == exDst);
    end
  endgenerate

  always_comb begin
    loadWriter     = exRegWr && exLoad && (exDst != '0);
    useHit         = loadWriter && (|srcMatch);
    strobes.bubble = useHit;
    strobes.pcEn   = !useHit;
    strobes.fdEn   = !useHit;
  end
endmodule

// File: rtl/pipeDatapath.sv
module pipeDatapath
  import lus_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int TAG_W = 8,
  parameter int PC_W  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  lus_strobe_t                   strobes,
  input  logic [TAG_W-1:0]              fetchTag,
  input  logic [REG_W-1:0]              fetchDst,
  input  logic [REG_W-1:0]              fetchSrc1,
  input  logic [REG_W-1:0]              fetchSrc2,
  input  logic                          fetchRegWr,
  input  logic                          fetchMemWr,
  input  logic                          fetchLoad,
  output logic [PC_W-1:0]               pc,
  output logic [SRC_CNT-1:0][REG_W-1:0] decSrc,
  output logic [TAG_W-1:0]              decTag,
  output logic [TAG_W-1:0]              exTag,
  output logic [REG_W-1:0]              exDst,
  output logic                          exRegWr,
  output logic                          exMemWr,
  output logic                          exLoad,
  output logic [TAG_W-1:0]              memTag,
  output logic                          memRegWr
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  // fetch/decode latch
  logic [TAG_W-1:0] fdTag;
  logic [REG_W-1:0] fdDst, fdSrc1, fdSrc2;
  logic             fdRegWr, fdMemWr, fdLoad;
  // decode/execute latch
  logic [TAG_W-1:0] deTag;
  logic [REG_W-1:0] deDst;
  logic             deRegWr, deMemWr, deLoad;
  // execute/memory latch
  logic [TAG_W-1:0] emTag;
  logic             emRegWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0;
    end else if (strobes.pcEn) begin
      pc <= pc + PC_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fdTag   <= '0;
      fdDst   <= '0;
      fdSrc1  <= '0;
      fdSrc2  <= '0;
      fdRegWr <= 1'b0;
      fdMemWr <= 1'b0;
      fdLoad  <= 1'b0;
    end else if (strobes.fdEn) begin
      fdTag   <= fetchTag;
      fdDst   <= fetchDst;
      fdSrc1  <= fetchSrc1;
      fdSrc2  <= fetchSrc2;
      fdRegWr <= fetchRegWr;
      fdMemWr <= fetchMemWr;
      fdLoad  <= fetchLoad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.bubble) begin
      deTag   <= '0;
      deDst   <= '0;
      deRegWr <= 1'b0;
      deMemWr <= 1'b0;
      deLoad  <= 1'b0;
    end else begin
      deTag   <= fdTag;
      deDst   <= fdDst;
      deRegWr <= fdRegWr;
      deMemWr <= fdMemWr;
      deLoad  <= fdLoad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emTag   <= '0;
      emRegWr <= 1'b0;
    end else begin
      emTag   <= deTag;
      emRegWr <= deRegWr;
    end
  end

  assign decSrc[0] = fdSrc1;
  assign decSrc[1] = fdSrc2;
  assign decTag    = fdTag;
  assign exTag     = deTag;
  assign exDst     = deDst;
  assign exRegWr   = deRegWr;
  assign exMemWr   = deMemWr;
  assign exLoad    = deLoad;
  assign memTag    = emTag;
  assign memRegWr  = emRegWr;
endmodule

// File: rtl/loadUseStall.sv
module loadUseStall
  import lus_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int TAG_W = 8,
  parameter int PC_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TAG_W-1:0] fetchTag,
  input  logic [REG_W-1:0] fetchDst,
  input  logic [REG_W-1:0] fetchSrc1,
  input  logic [REG_W-1:0] fetchSrc2,
  input  logic             fetchRegWr,
  input  logic             fetchMemWr,
  input  logic             fetchLoad,
  output logic [PC_W-1:0]  pc,
  output logic             pcEn,
  output logic             fdEn,
  output logic             bubble,
  output logic [TAG_W-1:0] decTag,
  output logic [TAG_W-1:0] exTag,
  output logic [REG_W-1:0] exDst,
  output logic             exRegWr,
  output logic             exMemWr,
  output logic             exLoad,
  output logic [TAG_W-1:0] memTag,
  output logic             memRegWr
);
  lus_strobe_t                   strobes;
  logic [SRC_CNT-1:0][REG_W-1:0] decSrc;

  hazardCtrl #(.REG_W(REG_W)) u_ctrl (
    .decSrc  (decSrc),
    .exDst   (exDst),
    .exRegWr (exRegWr),
    .exLoad  (exLoad),
    .strobes (strobes)
  );

  pipeDatapath #(.REG_W(REG_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .fetchTag   (fetchTag),
    .fetchDst   (fetchDst),
    .fetchSrc1  (fetchSrc1),
    .fetchSrc2  (fetchSrc2),
    .fetchRegWr (fetchRegWr),
    .fetchMemWr (fetchMemWr),
    .fetchLoad  (fetchLoad),
    .pc         (pc),
    .decSrc     (decSrc),
    .decTag     (decTag),
    .exTag      (exTag),
    .exDst      (exDst),
    .exRegWr    (exRegWr),
    .exMemWr    (exMemWr),
    .exLoad     (exLoad),
    .memTag     (memTag),
    .memRegWr   (memRegWr)
  );

  assign pcEn   = strobes.pcEn;
  assign fdEn   = strobes.fdEn;
  assign bubble = strobes.bubble;
endmodule

// File: rtl/lusChecker.sv
module lusChecker #(
  parameter int REG_W = 5,
  parameter int TAG_W = 8,
  parameter int PC_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [PC_W-1:0]  pc,
  input logic             pcEn,
  input logic             fdEn,
  input logic             bubble,
  input logic [TAG_W-1:0] decTag,
  input logic [TAG_W-1:0] exTag,
  input logic [REG_W-1:0] exDst,
  input logic             exRegWr,
  input logic             exMemWr,
  input logic             exLoad,
  input logic [TAG_W-1:0] memTag,
  input logic             memRegWr
);
  a_r2_enables_low: assert property (@(posedge clk) disable iff (!rstN)
    bubble |-> (!pcEn && !fdEn));

  a_r2_enables_high: assert property (@(posedge clk) disable iff (!rstN)
    !bubble |-> (pcEn && fdEn));

  a_r2_hold_front: assert property (@(posedge clk) disable iff (!rstN)
    bubble |=> (pc == $past(pc) && decTag == $past(decTag)));

  a_r3_empty_slot: assert property (@(posedge clk) disable iff (!rstN)
    bubble |=> (!exRegWr && !exMemWr && !exLoad && exTag == '0));

  a_r4_load_advances: assert property (@(posedge clk) disable iff (!rstN)
    bubble |=> (memTag == $past(exTag) && memRegWr == $past(exRegWr)));

  a_r5_single_bubble: assert property (@(posedge clk) disable iff (!rstN)
    bubble |=> !bubble);

  a_r6_zero_dst: assert property (@(posedge clk) disable iff (!rstN)
    (exDst == '0) |-> !bubble);

  a_r1_needs_load: assert property (@(posedge clk) disable iff (!rstN)
    bubble |-> (exLoad && exRegWr));

  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    pcEn |=> (pc == $past(pc) + PC_W'(1)));
endmodule

bind loadUseStall lusChecker #(.REG_W(REG_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_lusChecker (
  .clk      (clk),
  .rstN     (rstN),
  .pc       (pc),
  .pcEn     (pcEn),
  .fdEn     (fdEn),
  .bubble   (bubble),
  .decTag   (decTag),
  .exTag    (exTag),
  .exDst    (exDst),
  .exRegWr  (exRegWr),
  .exMemWr  (exMemWr),
  .exLoad   (exLoad),
  .memTag   (memTag),
  .memRegWr (memRegWr)
);

// File: tb/test_loadUseStall.sv
module test_loadUseStall;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;
  localparam int TAG_W = 8;
  localparam int PC_W  = 8;
  localparam int PROG_LEN = 40;
  localparam int RUN_CYCLES = 34;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [TAG_W-1:0] fetchTag = '0;
  logic [REG_W-1:0] fetchDst = '0, fetchSrc1 = '0, fetchSrc2 = '0;
  logic             fetchRegWr = 1'b0, fetchMemWr = 1'b0, fetchLoad = 1'b0;
  logic [PC_W-1:0]  pc;
  logic             pcEn, fdEn, bubble;
  logic [TAG_W-1:0] decTag, exTag, memTag;
  logic [REG_W-1:0] exDst;
  logic             exRegWr, exMemWr, exLoad, memRegWr;

  loadUseStall #(.REG_W(REG_W), .TAG_W(TAG_W), .PC_W(PC_W)) i_loadUseStall (
    .clk(clk), .rstN(rstN),
    .fetchTag(fetchTag), .fetchDst(fetchDst), .fetchSrc1(fetchSrc1), .fetchSrc2(fetchSrc2),
    .fetchRegWr(fetchRegWr), .fetchMemWr(fetchMemWr), .fetchLoad(fetchLoad),
    .pc(pc), .pcEn(pcEn), .fdEn(fdEn), .bubble(bubble),
    .decTag(decTag), .exTag(exTag), .exDst(exDst), .exRegWr(exRegWr),
    .exMemWr(exMemWr), .exLoad(exLoad), .memTag(memTag), .memRegWr(memRegWr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;

  // program store, indexed by slot; tag of slot k is k+1
  int pDst[PROG_LEN], pS1[PROG_LEN], pS2[PROG_LEN];
  int pWr[PROG_LEN], pMw[PROG_LEN], pLd[PROG_LEN];
  int stallsOnTag[PROG_LEN+1];

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int k, input int d, input int s1, input int s2,
                     input int wr, input int mw, input int ld);
    pDst[k] = d; pS1[k] = s1; pS2[k] = s2; pWr[k] = wr; pMw[k] = mw; pLd[k] = ld;
  endtask

  function automatic int fld(input int tag, input int sel);
    if (tag == 0) return 0;
    case (sel)
      0: return pDst[tag-1];
      1: return pS1[tag-1];
      2: return pS2[tag-1];
      3: return pWr[tag-1];
      4: return pMw[tag-1];
      default: return pLd[tag-1];
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mPc, mFd, mDe, mEm, expStall, dDst, s1, s2;
    for (int k = 0; k < PROG_LEN; k++) put(k, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k <= PROG_LEN; k++) stallsOnTag[k] = 0;
    put(0, 2, 1, 0, 1, 0, 1);    // load r2
    put(1, 12, 2, 5, 1, 0, 0);   // uses r2 as src1 -> stall
    put(2, 13, 6, 2, 1, 0, 0);   // second follower of load: no stall
    put(3, 4, 1, 0, 1, 0, 1);    // load r4
    put(4, 14, 7, 8, 1, 0, 0);   // independent
    put(5, 15, 9, 4, 1, 0, 0);   // two slots after load: no stall
    put(6, 0, 1, 0, 1, 0, 1);    // load to r0
    put(7, 16, 0, 0, 1, 0, 0);   // reads r0: no stall
    put(8, 6, 1, 0, 1, 0, 1);    // load r6
    put(9, 7, 6, 0, 1, 0, 1);    // load r7 from r6 -> stall
    put(10, 17, 7, 3, 1, 0, 0);  // uses r7 -> stall
    put(11, 8, 1, 2, 1, 0, 0);   // alu write r8
    put(12, 18, 8, 8, 1, 0, 0);  // non-load producer: no stall
    put(13, 9, 1, 2, 0, 1, 0);   // store
    put(14, 19, 9, 9, 1, 0, 0);  // no stall
    put(15, 10, 1, 0, 0, 0, 1);  // load flag without reg write
    put(16, 20, 10, 10, 1, 0, 0);// no stall
    put(17, 11, 1, 0, 1, 0, 1);  // load r11
    put(18, 21, 3, 11, 1, 0, 0); // uses r11 as src2 -> stall

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    chk("R9", "pc", int'(pc), 0);
    chk("R9", "bubble", int'(bubble), 0);
    chk("R9", "pcEn", int'(pcEn), 1);
    chk("R9", "fdEn", int'(fdEn), 1);
    chk("R9", "decTag", int'(decTag), 0);
    chk("R9", "exTag", int'(exTag), 0);
    chk("R9", "exRegWr", int'(exRegWr), 0);
    chk("R9", "memTag", int'(memTag), 0);

    mPc = 0; mFd = 0; mDe = 0; mEm = 0;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      dDst = fld(mDe, 0);
      s1 = fld(mFd, 1);
      s2 = fld(mFd, 2);
      expStall = (mFd != 0 && fld(mDe, 3) == 1 && fld(mDe, 5) == 1 && dDst != 0 &&
                  (dDst == s1 || dDst == s2)) ? 1 : 0;
      chk("R1", "bubble", int'(bubble), expStall);
      chk("R2", "pcEn", int'(pcEn), 1 - expStall);
      chk("R2", "fdEn", int'(fdEn), 1 - expStall);
      chk("R10", "pc", int'(pc), mPc);
      chk("R2", "decTag", int'(decTag), mFd);
      chk("R3", "exTag", int'(exTag), mDe);
      chk("R3", "exRegWr", int'(exRegWr), fld(mDe, 3));
      chk("R3", "exMemWr", int'(exMemWr), fld(mDe, 4));
      chk("R3", "exLoad", int'(exLoad), fld(mDe, 5));
      chk("R4", "memTag", int'(memTag), mEm);
      chk("R4", "memRegWr", int'(memRegWr), fld(mEm, 3));
      if (bubble) stallsOnTag[decTag] = stallsOnTag[decTag] + 1;
      // present slot at current pc
      fetchTag   = TAG_W'(int'(pc) + 1);
      fetchDst   = REG_W'(pDst[pc]);
      fetchSrc1  = REG_W'(pS1[pc]);
      fetchSrc2  = REG_W'(pS2[pc]);
      fetchRegWr = pWr[pc][0];
      fetchMemWr = pMw[pc][0];
      fetchLoad  = pLd[pc][0];
      @(posedge clk);
      mEm = mDe;
      if (expStall == 1) begin
        mDe = 0;
      end else begin
        mDe = mFd;
        mFd = mPc + 1;
        mPc = mPc + 1;
      end
      @(negedge clk);
    end

    chk("R1", "stalls on src1 consumer", stallsOnTag[2], 1);
    chk("R5", "stalls on second follower", stallsOnTag[3], 0);
    chk("R5", "stalls two slots after load", stallsOnTag[6], 0);
    chk("R7", "stalls on independent", stallsOnTag[5], 0);
    chk("R6", "stalls on r0 reader", stallsOnTag[8], 0);
    chk("R8", "stalls on chained load", stallsOnTag[10], 1);
    chk("R8", "stalls on chain consumer", stallsOnTag[11], 1);
    chk("R7", "stalls after alu producer", stallsOnTag[13], 0);
    chk("R7", "stalls after store", stallsOnTag[15], 0);
    chk("R7", "stalls after write-less load", stallsOnTag[17], 0);
    chk("R1", "stalls on src2 consumer", stallsOnTag[19], 1);
    begin
      int sum = 0;
      for (int k = 0; k <= PROG_LEN; k++) sum += stallsOnTag[k];
      chk("R5", "total bubbles", sum, 4);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule